// File: doc/BRIEF.md
# Watchdog Countdown Timer with Register Port

This block is a hardware watchdog. A prescaler divides the system clock into coarse ticks, and a down-counter loses one count per tick. Software keeps the system alive by writing the reload register, which copies the programmed timeout into the counter. If the counter runs out once, a timeout flag is raised and the count starts again. If it runs out a second time with no reload in between, the block pulses a reset request for one clock cycle.

Software uses a small 16-bit register window with byte enables. It sets the timeout in ticks, reads the live count, halts or runs the timer, clears the sticky flags and controls a reboot-suppress flag. A strap input can hold that flag set, and the read-back shows when a clear has been overridden. After reset the timer is halted and reboot is suppressed, so nothing fires until software arms the block.

Register offsets (byte addresses): 0x00 reload / live count, 0x04 first status, 0x06 second status, 0x08 control, 0x0C reboot-suppress, 0x12 timeout value. A write counts only when `wr_en_i` is high and at least one byte enable is set.

Top module: `wdog_regblk`

## Requirements
- R1: After reset the live count reads 4, the timeout value reads 4, control reads 0x0800 (halted), reboot-suppress reads 1, both status registers read 0 and `rst_req_o` is low.
- R2: A write to 0x12 stores bits [9:0] as the timeout value when the merged value is 4 or more. Bits [15:10] always read 0, whatever is written to them.
- R3: A write to 0x12 whose merged bits [9:0] are 0, 1, 2 or 3 is ignored, and the previous timeout value is kept.
- R4: Any write to 0x00, whatever its data, loads the counter from the timeout value and restarts the tick prescaler. A read of 0x00 returns the live count in bits [9:0].
- R5: While control bit 11 is 0, the count falls by one every TICK_DIV clock cycles, counted from the reload or from the halt release. While bit 11 is 1, the count holds. Control reads back bit 11 as last written.
- R6: When a tick arrives at count 0 and no earlier underflow is pending, bit 3 of status 0x04 is set and the counter reloads from the timeout value.
- R7: When a tick arrives at count 0 after such an underflow, with no software reload in between, bit 1 of status 0x06 is set and the counter reloads. If reboot-suppress is clear, `rst_req_o` goes high for exactly one cycle.
- R8: While reboot-suppress is effective, a second underflow leaves `rst_req_o` low and sets bit 0 of status 0x06 as well as bit 1.
- R9: Status bits are cleared by writing 1 to them. Writing 0 has no effect. Writing 3 to 0x06 clears both of its bits. A set event in the same cycle wins over a clear.
- R10: Register 0x0C bit 0 reads back the effective reboot-suppress flag. This is the written bit ORed with `noreboot_strap_i`, so a clear attempt while the strap is high still reads 1.
- R11: Read data appears on `rdata_o` on the cycle after `rd_en_i` is high, and holds until the next read.
- R12: Byte enables select which bytes of a write take effect. A byte whose enable is low keeps its old contents, and the value check of R3 is applied to the merged result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noreboot_strap_i | input | 1 | Strap that holds reboot-suppress set |
| addr_i | input | 5 | Byte address within the register window |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 0 for [7:0], bit 1 for [15:8] |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Every write takes effect at the clock edge that samples it. A read returns the state as it stood after the edge before the sampling edge, so the bench reads the count k cycles after a halt release and expects `init - (floor(k/TICK_DIV) mod (init+1))`. The first underflow lands at edge (init+1)·TICK_DIV after the release, and the status read is placed one cycle before and one cycle after that edge. `rst_req_o` is sampled at every falling edge through two full periods and must be high only on the cycle after edge 2·(init+1)·TICK_DIV. The bench moves inputs only on falling edges, so each expected value lines up with a counted number of rising edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int INIT_MIN = 4;

  localparam logic [ADDR_W-1:0] A_CNT  = 5'h00;
  localparam logic [ADDR_W-1:0] A_STS1 = 5'h04;
  localparam logic [ADDR_W-1:0] A_STS2 = 5'h06;
  localparam logic [ADDR_W-1:0] A_CTL  = 5'h08;
  localparam logic [ADDR_W-1:0] A_NRB  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_INIT = 5'h12;

  localparam int HALT_BIT = 11;
  localparam int TOUT_BIT = 3;

  // Merge a write into an old word under byte enables.
  function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_v,
                                                    input logic [DATA_W-1:0] new_v,
                                                    input logic [1:0]        be);
    merge_bytes = {be[1] ? new_v[15:8] : old_v[15:8],
                   be[0] ? new_v[7:0]  : old_v[7:0]};
  endfunction

  // Write-one-to-clear with set priority.
  function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
    w1c_next = set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 60_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 pre_q <= '0;
    else if (!run || restart)   pre_q <= '0;
    else if (tick)              pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W   = 10,
  parameter int RST_VAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             first_uf,
  output logic             second_uf
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             at_zero;

  assign at_zero   = (cnt_q == '0);
  assign first_uf  = tick && at_zero && !armed_q;
  assign second_uf = tick && at_zero && armed_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= CNT_W'(RST_VAL);
      armed_q <= 1'b0;
    end else if (reload) begin
      cnt_q   <= init_val;
      armed_q <= 1'b0;
    end else if (tick) begin
      if (at_zero) begin
        cnt_q   <= init_val;
        armed_q <= !armed_q;
      end else begin
        cnt_q   <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_regblk.sv
module wdog_regblk
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 60_000_000,
  parameter int CNT_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              noreboot_strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  localparam logic [CNT_W-1:0] INIT_RST = CNT_W'(INIT_MIN);

  logic              wr_any;
  logic              reload_wr, sts1_wr, sts2_wr, ctl_wr, nrb_wr, init_wr;
  logic              tick, first_uf, second_uf;
  logic [CNT_W-1:0]  cnt, init_q, init_cand;
  logic              init_accept;
  logic              halt_q, nrb_q, nr_eff;
  logic              sts1_tout_q;
  logic [1:0]        sts2_q;
  logic              rst_req_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  // Decoded write events
  assign wr_any    = wr_en_i && (be_i != 2'b00);
  assign reload_wr = wr_any && (addr_i == A_CNT);
  assign sts1_wr   = wr_any && (addr_i == A_STS1);
  assign sts2_wr   = wr_any && (addr_i == A_STS2);
  assign ctl_wr    = wr_any && (addr_i == A_CTL);
  assign nrb_wr    = wr_any && (addr_i == A_NRB);
  assign init_wr   = wr_any && (addr_i == A_INIT);

  assign nr_eff    = nrb_q | noreboot_strap_i;

  always_comb begin
    init_cand   = CNT_W'(merge_bytes(DATA_W'(init_q), wdata_i, be_i));
    init_accept = init_wr && (init_cand >= INIT_RST);
  end

  wdog_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!halt_q),
    .restart (reload_wr),
    .tick    (tick)
  );

  wdog_countdown #(.CNT_W(CNT_W), .RST_VAL(INIT_MIN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .reload    (reload_wr),
    .init_val  (init_q),
    .cnt_o     (cnt),
    .first_uf  (first_uf),
    .second_uf (second_uf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q      <= 1'b1;
      nrb_q       <= 1'b1;
      init_q      <= INIT_RST;
      sts1_tout_q <= 1'b0;
      sts2_q      <= 2'b00;
      rst_req_q   <= 1'b0;
    end else begin
      if (ctl_wr && be_i[1]) halt_q <= wdata_i[HALT_BIT];
      if (nrb_wr && be_i[0]) nrb_q  <= wdata_i[0];
      if (init_accept)       init_q <= init_cand;
      sts1_tout_q <= w1c_next(sts1_tout_q, first_uf,
                              sts1_wr && be_i[0] && wdata_i[TOUT_BIT]);
      sts2_q[1]   <= w1c_next(sts2_q[1], second_uf,
                              sts2_wr && be_i[0] && wdata_i[1]);
      sts2_q[0]   <= w1c_next(sts2_q[0], second_uf && nr_eff,
                              sts2_wr && be_i[0] && wdata_i[0]);
      rst_req_q   <= second_uf && !nr_eff;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CNT:   rd_mux = DATA_W'(cnt);
      A_STS1:  rd_mux[TOUT_BIT] = sts1_tout_q;
      A_STS2:  rd_mux[1:0] = sts2_q;
      A_CTL:   rd_mux[HALT_BIT] = halt_q;
      A_NRB:   rd_mux[0] = nr_eff;
      A_INIT:  rd_mux = DATA_W'(init_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdog_regblk_chk.sv
module wdog_regblk_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             first_uf,
  input logic             second_uf,
  input logic             reload_wr,
  input logic             halt_q,
  input logic             nr_eff,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_q,
  input logic             sts1_tout_q,
  input logic             rst_req_o
);
  // R7
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  // R7
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(second_uf));

  // R8
  nrb_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> !$past(nr_eff));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !reload_wr) |=> $stable(cnt));

  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (cnt == $past(init_q)));

  // R3
  init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(4));

  // R6
  tout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_uf |=> sts1_tout_q);
endmodule

bind wdog_regblk wdog_regblk_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .first_uf    (first_uf),
  .second_uf   (second_uf),
  .reload_wr   (reload_wr),
  .halt_q      (halt_q),
  .nr_eff      (nr_eff),
  .cnt         (cnt),
  .init_q      (init_q),
  .sts1_tout_q (sts1_tout_q),
  .rst_req_o   (rst_req_o)
);

// File: tb/wdog_regblk_bench.sv
module wdog_regblk_bench;
  localparam int D    = 4;
  localparam int CW   = 10;
  localparam int PER  = 2 * (5 + 1) * D;  // two periods with timeout value 5

  localparam logic [4:0] A_CNT = 5'h00, A_STS1 = 5'h04, A_STS2 = 5'h06,
                         A_CTL = 5'h08, A_NRB = 5'h0C, A_INIT = 5'h12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdog_regblk #(.TICK_DIV(D), .CNT_W(CW)) u_wdog_regblk (
    .clk (clk), .rst_n (rst_n), .noreboot_strap_i (strap),
    .addr_i (addr), .wdata_i (wdata), .be_i (be),
    .wr_en_i (wr_en), .rd_en_i (rd_en),
    .rdata_o (rdata), .rst_req_o (rst_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] b = 2'b11);
    addr = a; wdata = d; be = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; be = 2'b00;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Halt, reload, release: the release edge is the reference edge (k = 0).
  task automatic restart();
    wr(A_CTL, 16'h0800);
    wr(A_CNT, 16'h5A5A);
    wr(A_CTL, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x0000 expected 0x0001");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int model;
    int hi;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rst_req", {15'd0, rst_req}, 16'h0000);
    rd(A_CNT, v);  chk("R1 count", v, 16'd4);
    rd(A_STS1, v); chk("R1 status1", v, 16'h0000);
    rd(A_STS2, v); chk("R1 status2", v, 16'h0000);
    rd(A_NRB, v);  chk("R1 noreboot", v, 16'h0001);
    rd(A_INIT, v); chk("R1 timeout", v, 16'd4);
    // R11: data of the new read is not visible before the sampling edge
    addr = A_CTL; rd_en = 1'b1;
    #1 chk("R11 before edge", rdata, 16'd4);
    @(negedge clk); rd_en = 1'b0;
    chk("R1 control", rdata, 16'h0800);
    idle(3);
    chk("R11 held", rdata, 16'h0800);

    // R2 / R3 sweep of every timeout value, with junk in the upper bits
    model = 4;
    for (int i = 0; i < 1024; i++) begin
      wr(A_INIT, {6'h2A, 10'(i)});
      if (i >= 4) model = i;
      rd(A_INIT, v);
      if (i < 4) chk("R3 small timeout ignored", v, 16'(model));
      else       chk("R2 timeout stored", v, 16'(model));
    end

    // R12 byte enables
    wr(A_INIT, 16'h02AB);
    wr(A_INIT, 16'h0012, 2'b01); rd(A_INIT, v); chk("R12 low byte", v, 16'h0212);
    wr(A_INIT, 16'h0100, 2'b10); rd(A_INIT, v); chk("R12 high byte", v, 16'h0112);
    wr(A_INIT, 16'h0002, 2'b01); rd(A_INIT, v); chk("R12 low byte", v, 16'h0102);
    wr(A_INIT, 16'h0000, 2'b10); rd(A_INIT, v); chk("R12 R3 merged 2 ignored", v, 16'h0102);
    wr(A_INIT, 16'hFFFF, 2'b00); rd(A_INIT, v); chk("R12 no enables", v, 16'h0102);

    // R4 / R5 count sweep with timeout 5
    wr(A_INIT, 16'd5);
    for (int k = 0; k < PER; k++) begin
      restart();
      idle(k);
      rd(A_CNT, v);
      chk("R5 R6 count", v, 16'(5 - ((k / D) % 6)));
    end
    wr(A_CTL, 16'h0800);

    // R4 reload with arbitrary data mid-run
    restart(); idle(10);
    wr(A_CNT, 16'hFFFF);
    rd(A_CNT, v); chk("R4 reload", v, 16'd5);

    // R5 halt freezes the count
    restart(); idle(10);
    wr(A_CTL, 16'h0800);
    idle(40);
    rd(A_CNT, v); chk("R5 halted count", v, 16'd3);
    rd(A_CTL, v); chk("R5 control read", v, 16'h0800);

    // R6 flag timing around the first underflow
    wr(A_STS1, 16'h0008); wr(A_STS2, 16'h0003);
    restart(); idle((5 + 1) * D - 1);
    rd(A_STS1, v); chk("R6 before underflow", v, 16'h0000);
    rd(A_STS1, v); chk("R6 after underflow", v, 16'h0008);
    wr(A_CTL, 16'h0800);

    // R7 single reset pulse after second underflow
    wr(A_NRB, 16'h0000);
    wr(A_STS1, 16'h0008); wr(A_STS2, 16'h0003);
    restart();
    hi = 0;
    for (int k = 0; k <= PER + 4; k++) begin
      if (k == PER) chk("R7 pulse high", {15'd0, rst_req}, 16'h0001);
      else if (rst_req) hi++;
      @(negedge clk);
    end
    chk("R7 no other pulse", 16'(hi), 16'h0000);
    wr(A_CTL, 16'h0800);
    rd(A_STS2, v); chk("R7 status2", v, 16'h0002);
    rd(A_STS1, v); chk("R6 status1", v, 16'h0008);

    // R4 / R7 reload between underflows restarts the two-step sequence
    wr(A_STS2, 16'h0003);
    restart(); idle(30);
    wr(A_CNT, 16'h0000);
    hi = 0;
    for (int j = 0; j <= PER; j++) begin
      if (j == PER) chk("R7 pulse after reload", {15'd0, rst_req}, 16'h0001);
      else if (rst_req) hi++;
      @(negedge clk);
    end
    chk("R4 reload cancels pending", 16'(hi), 16'h0000);
    wr(A_CTL, 16'h0800);

    // R8 suppression
    wr(A_NRB, 16'h0001);
    wr(A_STS1, 16'h0008); wr(A_STS2, 16'h0003);
    restart();
    hi = 0;
    for (int k = 0; k < PER + 8; k++) begin
      if (rst_req) hi++;
      @(negedge clk);
    end
    wr(A_CTL, 16'h0800);
    chk("R8 no reset", 16'(hi), 16'h0000);
    rd(A_STS2, v); chk("R8 status2", v, 16'h0003);

    // R9 write-one-to-clear
    wr(A_STS1, 16'h0000); rd(A_STS1, v); chk("R9 zero write", v, 16'h0008);
    wr(A_STS1, 16'h0008); rd(A_STS1, v); chk("R9 clear status1", v, 16'h0000);
    wr(A_STS2, 16'h0001); rd(A_STS2, v); chk("R9 clear bit0", v, 16'h0002);
    wr(A_STS2, 16'h0003); rd(A_STS2, v); chk("R9 clear status2", v, 16'h0000);

    // R10 strap
    strap = 1'b1;
    wr(A_NRB, 16'h0000); rd(A_NRB, v); chk("R10 strap holds", v, 16'h0001);
    strap = 1'b0;
    rd(A_NRB, v); chk("R10 strap released", v, 16'h0000);
    wr(A_NRB, 16'h0001); rd(A_NRB, v); chk("R10 set", v, 16'h0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule